// File: doc/BRIEF.md
# Store Queue with Read Bypass

This block sits between a write-through first-level cache and the next memory level. Stores coming down from the cache are parked in a small queue rather than sent on at once, and they drain to the next level in the order they were accepted, but only in cycles when no read needs the downstream port. A store to an address that is already queued updates the queued copy instead of taking a second slot.

Reads take precedence over every queued store. Each read is compared with all queued stores when it is accepted. On a match, the queued data is returned one cycle later and nothing goes downstream. Without a match, the read is sent to the next level ahead of the queued stores, and the returned data is passed up. One read is handled at a time.

Top module: `wbuf_top`

## Requirements
- R1: While reset is held and just after it is released, wr_ready and rd_ready are 1 and ds_valid and rsp_valid are 0.
- R2: Queued stores reach the downstream port (ds_we = 1) in the order they were first accepted, one store per ds_valid/ds_ready handshake, with the oldest entry presented.
- R3: Once DEPTH (default 4) distinct addresses are queued, wr_ready is 0 until an entry drains. The occupancy never exceeds DEPTH.
- R4: A store accepted for an address that is already queued, other than an entry leaving that cycle, replaces that entry's data in place. No extra downstream write results, and the surviving write carries the newest data.
- R5: A read that misses is presented downstream with ds_we = 0 and its address. It stays presented with the same address until ds_ready, and it is sent before any queued store.
- R6: A read whose address matches a queued store gives rsp_valid exactly one cycle after acceptance with that store's data, and no downstream read is presented for it.
- R7: For a read that misses, rsp_valid rises in the cycle after ds_rvalid, and rsp_data equals ds_rdata.
- R8: One read at a time. rd_ready is 0 from acceptance through the cycle of rsp_valid. rsp_valid lasts one cycle.
- R9: A read and a store accepted in the same cycle: the read sees the queue contents as they were before that store.
- R10: A store is presented downstream only in cycles where rd_valid is 0 and no read is in flight. A presented store may be withdrawn when a read arrives.
- R11: Every read returns the value of the last store accepted before it to that address. If no store went to that address, it returns the downstream memory's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_valid | input | 1 | Store request from the cache |
| wr_ready | output | 1 | Queue can accept a store |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| rd_valid | input | 1 | Read request from the cache |
| rd_ready | output | 1 | Read can be accepted |
| rd_addr | input | AW | Read address |
| rsp_valid | output | 1 | Read response, one-cycle pulse |
| rsp_data | output | DW | Read response data |
| ds_valid | output | 1 | Downstream request valid |
| ds_ready | input | 1 | Downstream accepts request |
| ds_we | output | 1 | 1 = store, 0 = read |
| ds_addr | output | AW | Downstream address |
| ds_wdata | output | DW | Downstream store data |
| ds_rvalid | input | 1 | Downstream read data valid |
| ds_rdata | input | DW | Downstream read data |

## Verification
- **Forwarded reads:** the response is due exactly one cycle after the accepting edge. The bench samples rsp_valid at the falling edge right after that edge and requires a latency of exactly one.
- **Missing reads:** the latency depends on the downstream model's ds_ready and its one-cycle return delay. The bench checks that the read request is visible at the falling edge after acceptance, then waits for rsp_valid and compares the data with the value computed from its own record of stores.
- **Full, merge and withdrawal states:** these are sampled at the falling edge after the edge that changed them.
- **Drain order:** this is checked from a log of downstream handshakes recorded at rising edges.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  // Read sequencer states
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_REQ  = 2'd1,
    RD_WAIT = 2'd2,
    RD_RESP = 2'd3
  } rd_state_e;

endpackage

// File: rtl/wbuf_match.sv
// Compares one key against every queue slot; slots hold unique addresses,
// so at most one compare is true.
module wbuf_match #(
  parameter int AW    = 8,
  parameter int DEPTH = 4,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]         slot_vld,
  input  logic [DEPTH-1:0][AW-1:0] slot_addr,
  input  logic [AW-1:0]            key,
  output logic                     hit,
  output logic [IW-1:0]            idx
);

  logic [DEPTH-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign eq[g] = slot_vld[g] && (slot_addr[g] == key);
    end
  endgenerate

  assign hit = |eq;

  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/wbuf_queue.sv
// Circular store queue with in-place merge and per-slot valid bits.
module wbuf_queue #(
  parameter int AW    = 8,
  parameter int DW    = 64,
  parameter int DEPTH = 4,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_en,
  input  logic                     merge_en,
  input  logic [IW-1:0]            merge_idx,
  input  logic [AW-1:0]            in_addr,
  input  logic [DW-1:0]            in_data,
  input  logic                     pop_en,
  output logic [DEPTH-1:0]         slot_vld,
  output logic [DEPTH-1:0][AW-1:0] slot_addr,
  output logic [DEPTH-1:0][DW-1:0] slot_data,
  output logic [IW-1:0]            head_idx,
  output logic [CW-1:0]            count,
  output logic                     full,
  output logic                     empty
);

  logic [DEPTH-1:0]         vld_q, vld_d;
  logic [IW-1:0]            head_q, head_d, tail_q, tail_d;
  logic [CW-1:0]            cnt_q, cnt_d;
  logic [DEPTH-1:0]         addr_we, data_we;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;

  function automatic logic [IW-1:0] ptr_inc(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
  endfunction

  // next state
  always_comb begin
    vld_d   = vld_q;
    head_d  = head_q;
    tail_d  = tail_q;
    cnt_d   = cnt_q;
    addr_we = '0;
    data_we = '0;
    if (pop_en) begin
      vld_d[head_q] = 1'b0;
      head_d        = ptr_inc(head_q);
    end
    if (push_en) begin
      vld_d[tail_q]   = 1'b1;
      tail_d          = ptr_inc(tail_q);
      addr_we[tail_q] = 1'b1;
      data_we[tail_q] = 1'b1;
    end
    if (merge_en) begin
      data_we[merge_idx] = 1'b1;
    end
    case ({push_en, pop_en})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  // payload storage, enabled per slot, not reset
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (addr_we[g]) addr_q[g] <= in_addr;
      end
      always_ff @(posedge clk) begin
        if (data_we[g]) data_q[g] <= in_data;
      end
    end
  endgenerate

  assign slot_vld  = vld_q;
  assign slot_addr = addr_q;
  assign slot_data = data_q;
  assign head_idx  = head_q;
  assign count     = cnt_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);

endmodule

// File: rtl/wbuf_rdctl.sv
// Single-outstanding read sequencer: forward, or go downstream and wait.
module wbuf_rdctl
  import wbuf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ready,
  input  logic          fwd_hit,
  input  logic [DW-1:0] fwd_data,
  output logic          rq_valid,
  output logic [AW-1:0] rq_addr,
  input  logic          rq_ready,
  input  logic          rs_valid,
  input  logic [DW-1:0] rs_data,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          busy
);

  rd_state_e     st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, data_in;
  logic          addr_we, data_we;

  always_comb begin
    st_d    = st_q;
    addr_we = 1'b0;
    data_we = 1'b0;
    data_in = rs_data;
    case (st_q)
      RD_IDLE: begin
        if (rd_valid) begin
          if (fwd_hit) begin
            data_we = 1'b1;
            data_in = fwd_data;
            st_d    = RD_RESP;
          end else begin
            addr_we = 1'b1;
            st_d    = RD_REQ;
          end
        end
      end
      RD_REQ: begin
        if (rq_ready) st_d = RD_WAIT;
      end
      RD_WAIT: begin
        if (rs_valid) begin
          data_we = 1'b1;
          st_d    = RD_RESP;
        end
      end
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RD_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (addr_we) addr_q <= rd_addr;
  end

  always_ff @(posedge clk) begin
    if (data_we) data_q <= data_in;
  end

  assign rd_ready  = (st_q == RD_IDLE);
  assign rq_valid  = (st_q == RD_REQ);
  assign rq_addr   = addr_q;
  assign rsp_valid = (st_q == RD_RESP);
  assign rsp_data  = data_q;
  assign busy      = (st_q != RD_IDLE);

endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
  parameter int AW    = 8,
  parameter int DW    = 64,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          ds_valid,
  input  logic          ds_ready,
  output logic          ds_we,
  output logic [AW-1:0] ds_addr,
  output logic [DW-1:0] ds_wdata,
  input  logic          ds_rvalid,
  input  logic [DW-1:0] ds_rdata
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]         slot_vld;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][DW-1:0] slot_data;
  logic [IW-1:0]            head_idx, w_idx, r_idx;
  logic [CW-1:0]            q_count;
  logic                     q_full, q_empty;
  logic                     w_hit, rd_fwd_hit;
  logic                     wr_fire, merge_en, push_en, pop_en;
  logic                     rq_valid, rd_busy, drain_ok;
  logic [AW-1:0]            rq_addr;

  // store side lookup (merge)
  wbuf_match #(.AW(AW), .DEPTH(DEPTH)) u_wmatch (
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr),
    .key       (wr_addr),
    .hit       (w_hit),
    .idx       (w_idx)
  );

  // read side lookup (forward)
  wbuf_match #(.AW(AW), .DEPTH(DEPTH)) u_rmatch (
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr),
    .key       (rd_addr),
    .hit       (rd_fwd_hit),
    .idx       (r_idx)
  );

  assign wr_ready = !q_full;
  assign wr_fire  = wr_valid && wr_ready;
  assign pop_en   = ds_valid && ds_ready && ds_we;
  // never merge into the entry that leaves this cycle
  assign merge_en = wr_fire && w_hit && !(pop_en && (w_idx == head_idx));
  assign push_en  = wr_fire && !merge_en;

  wbuf_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .merge_en  (merge_en),
    .merge_idx (w_idx),
    .in_addr   (wr_addr),
    .in_data   (wr_data),
    .pop_en    (pop_en),
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .head_idx  (head_idx),
    .count     (q_count),
    .full      (q_full),
    .empty     (q_empty)
  );

  wbuf_rdctl #(.AW(AW), .DW(DW)) u_rdctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .rd_ready  (rd_ready),
    .fwd_hit   (rd_fwd_hit),
    .fwd_data  (slot_data[r_idx]),
    .rq_valid  (rq_valid),
    .rq_addr   (rq_addr),
    .rq_ready  (ds_ready),
    .rs_valid  (ds_rvalid),
    .rs_data   (ds_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .busy      (rd_busy)
  );

  // downstream arbitration: read first, stores only when reads are quiet
  assign drain_ok = !rd_busy && !rd_valid && !q_empty;
  assign ds_valid = rq_valid || drain_ok;
  assign ds_we    = !rq_valid;
  assign ds_addr  = rq_valid ? rq_addr : slot_addr[head_idx];
  assign ds_wdata = slot_data[head_idx];

endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
  parameter int AW    = 8,
  parameter int DW    = 64,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic          ds_valid,
  input logic          ds_ready,
  input logic          ds_we,
  input logic [AW-1:0] ds_addr,
  input logic          ds_rvalid,
  input logic [DW-1:0] ds_rdata,
  input logic          fwd_hit,
  input logic [CW-1:0] q_count
);

  // read in flight, tracked from the upstream port only
  logic rd_open;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rd_open <= 1'b0;
    else if (rd_valid && rd_ready) rd_open <= 1'b1;
    else if (rsp_valid)            rd_open <= 1'b0;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH)); // R3

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && !ds_we && !ds_ready) |=> (ds_valid && !ds_we && $stable(ds_addr))); // R5

  AST_FWD_NO_DS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && fwd_hit) |=> (rsp_valid && !(ds_valid && !ds_we))); // R6

  AST_MISS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    ds_rvalid |=> (rsp_valid && rsp_data == $past(ds_rdata))); // R7

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open |-> !rd_ready); // R8

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8

  AST_NO_STORE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open |-> !(ds_valid && ds_we)); // R10

endmodule

bind wbuf_top wbuf_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .ds_valid  (ds_valid),
  .ds_ready  (ds_ready),
  .ds_we     (ds_we),
  .ds_addr   (ds_addr),
  .ds_rvalid (ds_rvalid),
  .ds_rdata  (ds_rdata),
  .fwd_hit   (rd_fwd_hit),
  .q_count   (q_count)
);

// File: tb/sim_wbuf_top.sv
module sim_wbuf_top;

  localparam int AW = 8;
  localparam int DW = 64;

  logic          clk, rst_n;
  logic          wr_valid, wr_ready;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          rd_valid, rd_ready;
  logic [AW-1:0] rd_addr;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          ds_valid, ds_ready, ds_we;
  logic [AW-1:0] ds_addr;
  logic [DW-1:0] ds_wdata;
  logic          ds_rvalid;
  logic [DW-1:0] ds_rdata;

  int errors = 0;
  int checks = 0;
  int mode   = 0;   // 0 hold ds_ready low, 1 always high, 2 alternate

  wbuf_top #(.AW(AW), .DW(DW), .DEPTH(4)) u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [DW-1:0] mval(input logic [AW-1:0] a);
    return 64'hC0DE_0000_0000_0000 | (64'(a) * 64'h0000_0001_0003_0005);
  endfunction

  // downstream memory model and handshake log
  logic [DW-1:0] mem [256];
  bit            mw  [256];
  bit            hkind [1024];
  logic [AW-1:0] haddr [1024];
  logic [DW-1:0] hdata [1024];
  int            hcnt, rreq_cyc;
  logic          pend;
  logic [AW-1:0] paddr;
  int            cyc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_ready  <= 1'b0;
      ds_rvalid <= 1'b0;
      ds_rdata  <= '0;
      pend      <= 1'b0;
      paddr     <= '0;
      hcnt      <= 0;
      rreq_cyc  <= 0;
      cyc       <= 0;
      for (int i = 0; i < 256; i++) mw[i] <= 1'b0;
    end else begin
      cyc       <= cyc + 1;
      ds_ready  <= (mode == 1) ? 1'b1 : (mode == 2) ? cyc[0] : 1'b0;
      ds_rvalid <= pend;
      ds_rdata  <= mw[paddr] ? mem[paddr] : mval(paddr);
      pend      <= 1'b0;
      if (ds_valid && !ds_we) rreq_cyc <= rreq_cyc + 1;
      if (ds_valid && ds_ready) begin
        if (hcnt < 1024) begin
          hkind[hcnt] <= ds_we;
          haddr[hcnt] <= ds_addr;
          hdata[hcnt] <= ds_wdata;
        end
        hcnt <= hcnt + 1;
        if (ds_we) begin
          mem[ds_addr] <= ds_wdata;
          mw[ds_addr]  <= 1'b1;
        end else begin
          pend  <= 1'b1;
          paddr <= ds_addr;
        end
      end
    end
  end

  // bench reference of the coherent memory view
  logic [DW-1:0] ref_v [256];
  bit            ref_w [256];

  function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
    return ref_w[a] ? ref_v[a] : mval(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // all tasks start and end in the low phase after a falling edge
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    wr_valid = 1'b0;
    ref_v[a] = d; ref_w[a] = 1'b1;
  endtask

  task automatic wait_rsp(output int lat, output logic [DW-1:0] d);
    lat = 1;
    #1;
    while (!rsp_valid && lat < 2000) begin @(negedge clk); #1; lat++; end
    d = rsp_data;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output int lat,
                         output logic [DW-1:0] d);
    rd_valid = 1'b1; rd_addr = a;
    #1;
    while (!rd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rd_valid = 1'b0;
    wait_rsp(lat, d);
  endtask

  task automatic wait_idle();
    int k = 0;
    @(negedge clk); #1;
    while (ds_valid && k < 2000) begin @(negedge clk); #1; k++; end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  localparam logic [DW-1:0] D1 = 64'h1111_0000_0000_0001;
  localparam logic [DW-1:0] D2 = 64'h2222_0000_0000_0002;
  localparam logic [DW-1:0] D3 = 64'h3333_0000_0000_0003;
  localparam logic [DW-1:0] D4 = 64'h4444_0000_0000_0004;
  localparam logic [DW-1:0] D5 = 64'h5555_0000_0000_0005;
  localparam logic [DW-1:0] V1 = 64'h7777_0000_0000_0001;
  localparam logic [DW-1:0] V2 = 64'h7777_0000_0000_0002;

  initial begin
    int            lat, rq0, hs0;
    logic [DW-1:0] d;
    for (int i = 0; i < 256; i++) begin ref_w[i] = 1'b0; ref_v[i] = '0; end
    rst_n = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(wr_ready && rd_ready && !ds_valid && !rsp_valid, "R1 in reset",
        {wr_ready, rd_ready, ds_valid, rsp_valid}, 4'b1100);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(wr_ready && rd_ready && !ds_valid && !rsp_valid, "R1 after reset",
        {wr_ready, rd_ready, ds_valid, rsp_valid}, 4'b1100);
    @(negedge clk);

    // fill with a merge, downstream stalled
    do_write(8'h10, D1);
    do_write(8'h20, D2);
    do_write(8'h10, D3);
    do_write(8'h30, D4);
    do_write(8'h40, D5);
    #1;
    chk(!wr_ready, "R3 full blocks stores", wr_ready, 0);
    chk(ds_valid && ds_we && ds_addr == 8'h10, "R2 oldest presented", ds_addr, 8'h10);
    chk(ds_wdata == D3, "R4 merged data in place", ds_wdata, D3);

    // forwarded read
    rq0 = rreq_cyc;
    do_read(8'h20, lat, d);
    chk(lat == 1, "R6 forward latency", lat, 1);
    chk(d == D2, "R6 forward data", d, D2);
    chk(!rd_ready, "R8 rd_ready low in response cycle", rd_ready, 0);
    @(negedge clk); #1;
    chk(!rsp_valid, "R8 response is one cycle", rsp_valid, 0);
    chk(rreq_cyc == rq0, "R6 no downstream read", rreq_cyc, rq0);

    // missing read ahead of four queued stores
    hs0 = hcnt;
    rd_valid = 1'b1; rd_addr = 8'h55;
    #1;
    chk(!(ds_valid && ds_we), "R10 store withdrawn for read", ds_valid, 0);
    @(negedge clk);
    rd_valid = 1'b0;
    #1;
    chk(ds_valid && !ds_we && ds_addr == 8'h55, "R5 read presented",
        {ds_valid, ds_we, ds_addr}, {2'b10, 8'h55});
    mode = 1;
    wait_rsp(lat, d);
    chk(d == mval(8'h55), "R7 miss data", d, mval(8'h55));
    wait_idle();
    chk(hcnt - hs0 == 5, "R4 one store per address", hcnt - hs0, 5);
    chk(hkind[hs0] == 1'b0, "R5 read first downstream", hkind[hs0], 0);
    chk(haddr[hs0+1] == 8'h10 && hdata[hs0+1] == D3, "R2 drain 0", haddr[hs0+1], 8'h10);
    chk(haddr[hs0+2] == 8'h20 && hdata[hs0+2] == D2, "R2 drain 1", haddr[hs0+2], 8'h20);
    chk(haddr[hs0+3] == 8'h30 && hdata[hs0+3] == D4, "R2 drain 2", haddr[hs0+3], 8'h30);
    chk(haddr[hs0+4] == 8'h40 && hdata[hs0+4] == D5, "R2 drain 3", haddr[hs0+4], 8'h40);
    chk(wr_ready, "R3 ready after drain", wr_ready, 1);

    // read after drain comes from memory
    do_read(8'h10, lat, d);
    chk(d == D3, "R11 drained value", d, D3);

    // same-cycle store and read on one address
    mode = 0;
    @(negedge clk);
    do_write(8'h70, V1);
    wr_valid = 1'b1; wr_addr = 8'h70; wr_data = V2;
    rd_valid = 1'b1; rd_addr = 8'h70;
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    ref_v[8'h70] = V2;
    #1;
    chk(rsp_valid && rsp_data == V1, "R9 read sees older contents", rsp_data, V1);
    @(negedge clk);
    do_read(8'h70, lat, d);
    chk(lat == 1 && d == V2, "R4 merged value forwarded", d, V2);
    mode = 1;
    wait_idle();

    // sweep of interleaved stores and reads, downstream ready alternating
    mode = 2;
    for (int i = 0; i < 240; i++) begin
      logic [AW-1:0] a;
      a = AW'((i * 5 + 3) % 12) + 8'h80;
      if (i % 4 == 3) begin
        do_read(a, lat, d);
        chk(d == expect_rd(a), "R11 sweep read", d, expect_rd(a));
      end else begin
        do_write(a, 64'(i) * 64'h0000_0001_0000_0001 + 64'd7);
      end
    end
    mode = 1;
    wait_idle();
    for (int j = 0; j < 12; j++) begin
      logic [AW-1:0] a;
      a = AW'(j) + 8'h80;
      do_read(a, lat, d);
      chk(d == expect_rd(a), "R11 final read-back", d, expect_rd(a));
    end
    report();
  end

endmodule